// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time as six packed-BCD byte fields: seconds, minutes, hours (24-hour only), day of month, month (01 to 12) and a two-digit year (00 to 99, meaning 2000 to 2099). A slow enable, `tick_en`, pulses once per period of a 32.768 kHz reference. A prescaler turns `PRESCALE` of those pulses into one seconds update. The update then ripples carries through the longer units. Day rollover follows month length, and February has 29 days in every year divisible by four.

A small register port reads and writes every field, a run control and a status byte. A three-state sequencer sets the timing. In Stopped (`SEQ_STOP`) the time holds. In Counting (`SEQ_COUNT`) the prescaler advances on each tick. In Guard (`SEQ_GUARD`) the status BUSY bit is high for the single tick period before a seconds update.

The transitions are:
- Stopped to Counting, or to Guard if the prescaler already sits on its last count, when run is set.
- Counting to Guard on the tick that brings the prescaler to its last count.
- Guard to Counting on the next tick. This tick performs the update.
- Any state to Stopped when run is cleared.
- Counting or Guard to Counting, with the prescaler at zero, when seconds is written while run is set.

Software polls BUSY low, then has the rest of a tick period to access the time fields safely. Four sticky flags record seconds, minute, hour and day boundaries. Software clears each flag by writing 1 to it.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, seconds/minutes/hours read 0x00, day and month read 0x01, year reads 0x00, and both the control byte (0x40) and the status byte (0x44) read 0x00.
- R2: The time fields sit at byte addresses seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14. A write loads the byte into that field unchanged, and a read returns it.
- R3: Control bit 0 set makes the calendar count, and status bit 1 then reads 1. With bit 0 clear, ticks change no field, status bit 1 reads 0 and BUSY stays low.
- R4: Control bit 3 (12/24-hour select) always reads 0. Hours count 00 to 23 and wrap from 0x23 to 0x00.
- R5: One seconds update occurs every `PRESCALE` ticks while running. Writing seconds restarts the prescaler at zero, so the next update comes on the `PRESCALE`-th tick after the write.
- R6: Status bit 0 (BUSY) is high exactly during the tick period that ends with a seconds update, and low at all other times.
- R7: Seconds wrap from 0x59 to 0x00 and advance minutes. Minutes wrap from 0x59 to 0x00 and advance hours.
- R8: When hours wrap, the day advances. After the last day of the month (31 for months 1, 3, 5, 7, 8, 10 and 12; 30 for 4, 6, 9 and 11; 29 for February when the year is divisible by 4, otherwise 28), the day returns to 0x01 and the month advances.
- R9: Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00.
- R10: Status bits 2, 3, 4 and 5 are set by a seconds update, a minute boundary, an hour boundary and a day boundary respectively, and stay set until cleared.
- R11: Writing the status byte clears each event flag whose bit in the written byte is 1 and leaves the others. A flag set by an update in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
A prescaler or sequencer state that is off by one shows at the ports within one second's worth of ticks. Either BUSY rises on the wrong tick, or the seconds field changes one tick early or late relative to a seconds write. A wrong month-length or leap decision stays hidden until a day boundary, so the stimulus parks the calendar at 23:59:59 on the last days of chosen months and years, where one update exposes it. A wrong carry or a flag that is not sticky shows in the status byte after the next update.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HOUR   = 2;
    localparam int FLD_DAY    = 3;
    localparam int FLD_MON    = 4;
    localparam int FLD_YEAR   = 5;
    localparam int NUM_EVENTS = 4;

    localparam logic [7:0] ADDR_CTRL = 8'h40;
    localparam logic [7:0] ADDR_STAT = 8'h44;

    typedef enum logic [1:0] {
        SEQ_STOP  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_GUARD = 2'd2
    } seq_state_e;

    // Next packed-BCD value (no upper limit applied here).
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Last day of a month, BCD in and out; leap when year divisible by 4.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic leap;
        if (yr[4])
            leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic step,
    output logic busy,
    output logic running
);

    localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRESCALE - 2);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] presc_q, presc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_STOP;
            presc_q <= '0;
        end else begin
            state_q <= state_d;
            presc_q <= presc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        presc_d = presc_q;
        unique case (state_q)
            SEQ_STOP: begin
                if (run)
                    state_d = (presc_q == LAST) ? SEQ_GUARD : SEQ_COUNT;
            end
            SEQ_COUNT: begin
                if (!run) begin
                    state_d = SEQ_STOP;
                end else if (tick) begin
                    presc_d = presc_q + 1'b1;
                    if (presc_q == PRE_LAST)
                        state_d = SEQ_GUARD;
                end
            end
            SEQ_GUARD: begin
                if (!run) begin
                    state_d = SEQ_STOP;
                end else if (tick) begin
                    presc_d = '0;
                    state_d = SEQ_COUNT;
                end
            end
            default: state_d = SEQ_STOP;
        endcase
        if (restart) begin
            presc_d = '0;
            state_d = run ? SEQ_COUNT : SEQ_STOP;
        end
    end

    always_comb begin
        busy    = (state_q == SEQ_GUARD);
        running = (state_q != SEQ_STOP);
        step    = (state_q == SEQ_GUARD) && tick && run && !restart;
    end

    assert_busy_one_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && run && !restart) |=> !busy);

    assert_stop_no_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!busy && !step));

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
    import cal_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic [NUM_FIELDS-1:0]      fld_we,
    input  logic [7:0]                 wdata,
    output logic [NUM_FIELDS-1:0][7:0] fields,
    output logic [NUM_EVENTS-1:0]      roll
);

    logic [NUM_FIELDS-1:0]      adv;
    logic [NUM_FIELDS-1:0][7:0] top_v;

    always_comb begin
        top_v[FLD_SEC]  = 8'h59;
        top_v[FLD_MIN]  = 8'h59;
        top_v[FLD_HOUR] = 8'h23;
        top_v[FLD_DAY]  = month_last_day(fields[FLD_MON], fields[FLD_YEAR]);
        top_v[FLD_MON]  = 8'h12;
        top_v[FLD_YEAR] = 8'h99;
    end

    assign adv[0] = step;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [7:0] BASE = (i == FLD_DAY || i == FLD_MON) ? 8'h01 : 8'h00;
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= BASE;
            else if (fld_we[i])
                q <= wdata;
            else if (adv[i])
                q <= (q == top_v[i]) ? BASE : bcd_next(q);
        end
        assign fields[i] = q;
        if (i < NUM_FIELDS - 1) begin : g_carry
            assign adv[i+1] = adv[i] && (q == top_v[i]);
        end
    end

    assign roll = adv[NUM_EVENTS-1:0];

    assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && fields[FLD_SEC] == 8'h59 && !fld_we[FLD_SEC]) |=> fields[FLD_SEC] == 8'h00);

    assert_day_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv[FLD_DAY] && fields[FLD_DAY] == top_v[FLD_DAY] && !fld_we[FLD_DAY])
        |=> fields[FLD_DAY] == 8'h01);

endmodule

// File: rtl/cal_event_flags.sv
module cal_event_flags
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] set_ev,
    input  logic                  clr_we,
    input  logic [NUM_EVENTS-1:0] clr_mask,
    output logic [NUM_EVENTS-1:0] flags
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~(clr_we ? clr_mask : '0)) | set_ev;
    end

    assert_carry_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[2] |-> (set_ev[1] && set_ev[0]));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[0] |=> flags[0]);

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    logic                       run_q;
    logic                       step, busy, running;
    logic [NUM_FIELDS-1:0]      fld_we;
    logic [NUM_FIELDS-1:0][7:0] fields;
    logic [NUM_EVENTS-1:0]      roll, flags;
    logic                       stat_we;

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++)
            fld_we[i] = bus_wr && (bus_addr == 8'(4 * i));
    end

    assign stat_we = bus_wr && (bus_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            run_q <= bus_wdata[0];
    end

    cal_sequencer #(.PRESCALE(PRESCALE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .run     (run_q),
        .restart (fld_we[FLD_SEC]),
        .step    (step),
        .busy    (busy),
        .running (running)
    );

    cal_time_chain u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .fld_we (fld_we),
        .wdata  (bus_wdata),
        .fields (fields),
        .roll   (roll)
    );

    cal_event_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (roll),
        .clr_we   (stat_we),
        .clr_mask (bus_wdata[2 +: NUM_EVENTS]),
        .flags    (flags)
    );

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (bus_addr == 8'(4 * i))
                bus_rdata = fields[i];
        if (bus_addr == ADDR_CTRL)
            bus_rdata = {7'b0, run_q};
        if (bus_addr == ADDR_STAT)
            bus_rdata = {2'b00, flags, running, busy};
    end

    assert_update_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (busy && tick_en));

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_s, m_mi, m_h, m_d, m_mo, m_y, m_presc;
    bit m_run;
    logic [3:0] m_ev;

    bcd_calendar #(.PRESCALE(PRE)) i_bcd_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_run(bit r);
        wr(8'h40, {7'b0, r});
        m_run = r;
    endtask

    task automatic set_time(int y, int mo, int d, int h, int mi, int s);
        wr(8'h14, to_bcd(y));  m_y  = y;
        wr(8'h10, to_bcd(mo)); m_mo = mo;
        wr(8'h0C, to_bcd(d));  m_d  = d;
        wr(8'h08, to_bcd(h));  m_h  = h;
        wr(8'h04, to_bcd(mi)); m_mi = mi;
        wr(8'h00, to_bcd(s));  m_s  = s;
        m_presc = 0;
    endtask

    task automatic model_step();
        m_ev[0] = 1'b1;
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_ev[1] = 1'b1; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_ev[2] = 1'b1; m_h++;
                if (m_h == 24) begin
                    m_h = 0; m_ev[3] = 1'b1; m_d++;
                    if (m_d > days_in(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo > 12) begin
                            m_mo = 1;
                            m_y = (m_y + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_tick();
        if (m_run) begin
            if (m_presc == PRE - 1) begin
                model_step();
                m_presc = 0;
            end else begin
                m_presc++;
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        model_tick();
    endtask

    task automatic check_all(string req);
        logic [7:0] d;
        logic busy_exp;
        busy_exp = m_run && (m_presc == PRE - 1);
        rd(8'h00, d); check8(req, "seconds", d, to_bcd(m_s));
        rd(8'h04, d); check8(req, "minutes", d, to_bcd(m_mi));
        rd(8'h08, d); check8(req, "hours",   d, to_bcd(m_h));
        rd(8'h0C, d); check8(req, "day",     d, to_bcd(m_d));
        rd(8'h10, d); check8(req, "month",   d, to_bcd(m_mo));
        rd(8'h14, d); check8(req, "year",    d, to_bcd(m_y));
        rd(8'h44, d); check8(req, "status",  d, {2'b00, m_ev, m_run, busy_exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd7321));
        m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0;
        m_presc = 0; m_run = 1'b0; m_ev = 4'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check_all("R1");
        rd(8'h40, d); check8("R1", "control", d, 8'h00);

        // R2: direct field load and readback at each offset
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = to_bcd(int'($urandom_range(59, 0)));
            wr(8'(4 * k), v);
            rd(8'(4 * k), d);
            check8("R2", "field readback", d, v);
        end
        set_time(12, 6, 15, 10, 20, 30);
        check_all("R2");

        // R4: mode bit reads zero
        wr(8'h40, 8'h09);
        m_run = 1'b1;
        rd(8'h40, d); check8("R4", "control bit3", d, 8'h01);
        set_run(1'b0);

        // R3: stopped calendar ignores ticks
        for (int k = 0; k < 2 * PRE; k++) tick();
        check_all("R3");

        // R5 / R6: busy window and update timing while running
        set_run(1'b1);
        check_all("R3");
        for (int k = 0; k < 3 * PRE; k++) begin
            check_all("R6");
            tick();
        end
        tick();
        wr(8'h00, 8'h05);
        m_s = 5; m_presc = 0;
        for (int k = 0; k < PRE; k++) begin
            check_all("R5");
            tick();
        end
        check_all("R5");

        // R7: minute and hour carries
        set_time(40, 7, 10, 8, 59, 59);
        for (int k = 0; k < PRE; k++) tick();
        check_all("R7");

        // R4 / R8 / R9: directed calendar corners at 23:59:59
        begin
            int cy[8]  = '{24, 24, 23,  0, 25, 25, 99, 30};
            int cmo[8] = '{ 2,  2,  2,  2,  4,  1, 12, 12};
            int cd[8]  = '{28, 29, 28, 28, 30, 31, 31, 31};
            for (int k = 0; k < 8; k++) begin
                set_time(cy[k], cmo[k], cd[k], 23, 59, 59);
                for (int t = 0; t < PRE; t++) tick();
                check_all((k >= 6) ? "R9" : "R8");
                rd(8'h08, d); check8("R4", "hour wrap", d, 8'h00);
            end
        end

        // R11: write-one-to-clear, zero leaves flags
        wr(8'h44, 8'h00);
        check_all("R11");
        wr(8'h44, 8'h04); m_ev[0] = 1'b0;
        check_all("R11");
        wr(8'h44, 8'h3C); m_ev = 4'b0;
        check_all("R11");

        // R11: update in the same cycle as a clear keeps the flag
        while (m_presc != PRE - 1) tick();
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 8'h44; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        m_ev[0] = 1'b0;
        model_tick();
        check_all("R11");

        // R7 / R8 / R10: random near-rollover starts
        for (int it = 0; it < 20; it++) begin
            int y, mo, dd, h, mi, s, n;
            y  = int'($urandom_range(99, 0));
            mo = int'($urandom_range(12, 1));
            dd = ($urandom_range(1, 0) == 1) ? days_in(mo, y) : int'($urandom_range(days_in(mo, y), 1));
            h  = ($urandom_range(1, 0) == 1) ? 23 : int'($urandom_range(23, 0));
            mi = ($urandom_range(1, 0) == 1) ? 59 : int'($urandom_range(59, 0));
            s  = int'($urandom_range(59, 57));
            set_time(y, mo, dd, h, mi, s);
            n = int'($urandom_range(3 * PRE, 1));
            for (int t = 0; t < n; t++) tick();
            check_all("R10");
        end

        // R3: stop again, time holds
        set_run(1'b0);
        for (int k = 0; k < 2 * PRE; k++) tick();
        check_all("R3");

        finish_run();
    end

endmodule